// File: doc/BRIEF.md
# Interrupt Trigger Conditioner

This block turns raw external interrupt lines into clean, per-line trigger signals for the enable and status logic that sits downstream. Each line first passes through a two-flop synchroniser. Two configuration bits then decide how the line is read. With both bits clear, or both bits set, the line is treated as a level: active-high or active-low. With exactly one bit set, the line is edge-triggered, on the rising edge or on the falling edge. In an edge mode, a detected edge sets a sticky bit. That bit stays set until software acknowledges it by writing a one to it.

Software reaches the block through a plain register port. Writes take one cycle and reads are combinational. The lines are split into groups of 32, and each group has its own bank of eight word registers. The conditioned outputs leave the block on a plain vector that has no handshake. Masking of the lines is left to the logic downstream.

Top module: `trig_cond_top`

## Requirements
- R1: After reset, every rise bit, fall bit and sticky bit is 0, so every line is in active-high level mode.
- R2: Byte address bits [4:2] select the register within a group: 0 status, 1 edge latch (RAW), 2 rise bits, 3 fall bits, 4 rise-set, 5 rise-clear, 6 fall-set, 7 fall-clear. Address bits above bit 4 select the group, with a stride of 0x20, and a group number beyond the last group reads as 0. Write-only registers read as 0.
- R3: A write to rise-set or fall-set sets exactly the configuration bits written as 1 and leaves all other bits unchanged.
- R4: A write to rise-clear or fall-clear clears exactly the configuration bits written as 1 and leaves all other bits unchanged.
- R5: Rise=1 with fall=0 is rising-edge mode. A 0-to-1 transition of the synchronised input sets the line's sticky bit, and the line's status is the sticky bit.
- R6: Rise=0 with fall=1 is falling-edge mode. A 1-to-0 transition sets the sticky bit, and the line's status is the sticky bit.
- R7: Rise=0 with fall=0 is active-high level mode. The status equals the input, delayed by two clock cycles.
- R8: Rise=1 with fall=1 is active-low level mode. The status is the inverted input, delayed by two clock cycles.
- R9: Writing to the edge-latch register clears the sticky bits written as 1. Writing 0xFFFFFFFF clears all of them.
- R10: If an edge is detected in the same cycle as an acknowledge of the same line, the sticky bit ends up set.
- R11: In a level mode, a line's sticky bit stays 0, and acknowledge writes do not change its status.
- R12: The `cond_out` port always equals the status value of every line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_LINES | Raw interrupt lines, asynchronous |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | GROUP_W | Write data |
| reg_rdata | output | GROUP_W | Read data, combinational from reg_addr |
| cond_out | output | NUM_LINES | Conditioned trigger outputs |

## Verification
A wrong configuration bit shows up on the next read of the rise or fall register. It also changes the status of that line as soon as the following cycle. A sticky bit that is lost or set by mistake is visible on both `cond_out` and RAW three cycles after the input change that should (or should not) have set it. If the group decode is wrong, a write lands in the other group's bank, and that bank's readback exposes it immediately.

// File: rtl/trig_cond_pkg.sv
package trig_cond_pkg;
  localparam int REG_IDX_W = 3;
  localparam int GRP_LSB   = 5;

  typedef enum logic [REG_IDX_W-1:0] {
    RG_STATUS   = 3'd0,
    RG_LATCH    = 3'd1,
    RG_RISE     = 3'd2,
    RG_FALL     = 3'd3,
    RG_RISE_SET = 3'd4,
    RG_RISE_CLR = 3'd5,
    RG_FALL_SET = 3'd6,
    RG_FALL_CLR = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/trig_bank.sv
module trig_bank
  import trig_cond_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_in,
  input  logic         sel,
  input  logic         reg_wr,
  input  reg_idx_e     reg_idx,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cond,
  output logic [W-1:0] rd_data
);
  logic [W-1:0] prev_q, rise_q, fall_q, latch_q;
  logic [W-1:0] edge_mode, hit, ack;
  logic [W-1:0] rise_d, fall_d, latch_d;
  logic         wr_here;

  assign wr_here   = sel && reg_wr;
  assign edge_mode = rise_q ^ fall_q;
  assign hit       = (rise_q & ~fall_q & sync_in & ~prev_q)
                   | (~rise_q & fall_q & ~sync_in & prev_q);
  assign ack       = (wr_here && reg_idx == RG_LATCH) ? wdata : '0;

  always_comb begin
    rise_d = rise_q;
    fall_d = fall_q;
    if (wr_here) begin
      unique case (reg_idx)
        RG_RISE_SET: rise_d = rise_q | wdata;
        RG_RISE_CLR: rise_d = rise_q & ~wdata;
        RG_FALL_SET: fall_d = fall_q | wdata;
        RG_FALL_CLR: fall_d = fall_q & ~wdata;
        default: ;
      endcase
    end
    latch_d = (rise_d ^ fall_d) & ((latch_q & ~ack) | hit);
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prev_q  <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= sync_in;
      rise_q  <= rise_d;
      fall_q  <= fall_d;
      latch_q <= latch_d;
    end

  assign cond = (edge_mode & latch_q) | (~edge_mode & (sync_in ^ (rise_q & fall_q)));

  always_comb begin
    unique case (reg_idx)
      RG_STATUS: rd_data = cond;
      RG_LATCH:  rd_data = latch_q;
      RG_RISE:   rd_data = rise_q;
      RG_FALL:   rd_data = fall_q;
      default:   rd_data = '0;
    endcase
  end

  p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_here && reg_idx == RG_RISE_SET) |=> ((rise_q & $past(wdata)) == $past(wdata)));

  p_clr_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_here && reg_idx == RG_FALL_CLR) |=> ((fall_q & $past(wdata)) == '0));

  p_edge_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_here && |hit) |=> ((latch_q & $past(hit)) == $past(hit)));

  p_ack_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack) |=> ((latch_q & $past(ack & ~hit)) == '0));

  p_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ack & hit) && reg_idx == RG_LATCH) |=> ((latch_q & $past(ack & hit)) == $past(ack & hit)));
endmodule

// File: rtl/trig_cond_top.sv
module trig_cond_top
  import trig_cond_pkg::*;
#(
  parameter int NUM_LINES = 64,
  parameter int GROUP_W   = 32,
  parameter int ADDR_W    = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [GROUP_W-1:0]   reg_wdata,
  output logic [GROUP_W-1:0]   reg_rdata,
  output logic [NUM_LINES-1:0] cond_out
);
  localparam int NUM_GROUPS = NUM_LINES / GROUP_W;
  localparam int GSEL_W     = ADDR_W - GRP_LSB;

  logic [NUM_LINES-1:0] sync_lines;
  logic [GSEL_W-1:0]    grp;
  reg_idx_e             idx;
  logic [GROUP_W-1:0]   grp_rd [NUM_GROUPS];

  assign grp = reg_addr[ADDR_W-1:GRP_LSB];
  assign idx = reg_idx_e'(reg_addr[GRP_LSB-1:2]);

  trig_sync #(.W(NUM_LINES), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_in(irq_in), .d_out(sync_lines)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
    trig_bank #(.W(GROUP_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_in (sync_lines[g*GROUP_W +: GROUP_W]),
      .sel     (grp == GSEL_W'(g)),
      .reg_wr  (reg_wr),
      .reg_idx (idx),
      .wdata   (reg_wdata),
      .cond    (cond_out[g*GROUP_W +: GROUP_W]),
      .rd_data (grp_rd[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < NUM_GROUPS; g++)
      if (grp == GSEL_W'(g)) reg_rdata = grp_rd[g];
  end

  p_status_port_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (idx == RG_STATUS && grp == '0) |-> (reg_rdata == cond_out[GROUP_W-1:0]));
endmodule

// File: tb/test_trig_cond_top.sv
`timescale 1ns/1ps
module test_trig_cond_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] irq_in = '0;
  logic [6:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] cond_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [63:0] m_in = '0, m_rise = '0, m_fall = '0, m_lat = '0;

  always #2.5 clk = ~clk;

  trig_cond_top i_trig_cond_top (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cond_out(cond_out)
  );

  function automatic logic [63:0] exp_status();
    logic [63:0] em;
    em = m_rise ^ m_fall;
    return (em & m_lat) | (~em & (m_in ^ (m_rise & m_fall)));
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    int g;
    logic [63:0] m;
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    g = a[6:5];
    if (g < 2) begin
      m = 64'(d) << (32 * g);
      case (a[4:2])
        3'd1: m_lat  = m_lat & ~m;
        3'd4: m_rise = m_rise | m;
        3'd5: m_rise = m_rise & ~m;
        3'd6: m_fall = m_fall | m;
        3'd7: m_fall = m_fall & ~m;
        default: ;
      endcase
      m_lat = m_lat & (m_rise ^ m_fall);
    end
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic drive(input logic [63:0] v);
    logic [63:0] rm, fm;
    @(negedge clk);
    irq_in = v;
    rm = m_rise & ~m_fall;
    fm = ~m_rise & m_fall;
    m_lat = m_lat | (rm & v & ~m_in) | (fm & ~v & m_in);
    m_in = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    logic [63:0] es;
    es = exp_status();
    for (int g = 0; g < 2; g++) begin
      rd(7'(g * 32 + 0),  d); chk({tag, " status"}, 64'(d), 64'(es[g*32 +: 32]));
      rd(7'(g * 32 + 4),  d); chk({tag, " latch"},  64'(d), 64'(m_lat[g*32 +: 32]));
      rd(7'(g * 32 + 8),  d); chk({tag, " rise"},   64'(d), 64'(m_rise[g*32 +: 32]));
      rd(7'(g * 32 + 12), d); chk({tag, " fall"},   64'(d), 64'(m_fall[g*32 +: 32]));
    end
    chk({tag, " cond_out R12"}, cond_out, es);
  endtask

  task automatic set_modes(input int r);
    logic [31:0] rb, fb;
    for (int g = 0; g < 2; g++) begin
      rb = '0; fb = '0;
      for (int i = 0; i < 32; i++) begin
        int md;
        md = (i + r + g) % 4;
        rb[i] = (md == 1) || (md == 3);
        fb[i] = (md == 2) || (md == 3);
      end
      wr(7'(g * 32 + 20), 32'hffff_ffff);
      wr(7'(g * 32 + 28), 32'hffff_ffff);
      wr(7'(g * 32 + 16), rb);
      wr(7'(g * 32 + 24), fb);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R1 reset");

    drive(64'hdead_beef_0123_4567);
    check_all("R7 level high");
    drive(64'h0);
    check_all("R7 level low in");

    for (int r = 0; r < 4; r++) begin
      set_modes(r);
      check_all("R3 R4 mode program");
      drive(64'hffff_ffff_ffff_ffff);
      check_all("R5 R8 all high");
      drive(64'h0);
      check_all("R6 R8 all low");
      drive(64'ha5a5_5a5a_c3c3_3c3c ^ (64'h1 << (r * 7)));
      check_all("R5 R6 pattern");
      wr(7'h04, 32'h0f0f_0f0f);
      check_all("R9 partial ack");
      wr(7'h24, 32'hffff_ffff);
      check_all("R9 R11 ack all");
      drive(64'h0123_4567_89ab_cdef);
      check_all("R5 R6 R7 R8 second pattern");
    end

    wr(7'h14, 32'hffff_ffff); wr(7'h1c, 32'hffff_ffff);
    wr(7'h10, 32'h0000_00f0);
    check_all("R3 set only ones");
    wr(7'h18, 32'h0000_0f00);
    wr(7'h14, 32'h0000_0030);
    check_all("R4 clear only ones");
    drive(64'hffff_ffff_ffff_ffff);
    wr(7'h04, 32'hffff_ffff);
    check_all("R11 level lines ignore ack");

    wr(7'h14, 32'hffff_ffff); wr(7'h1c, 32'hffff_ffff);
    wr(7'h10, 32'h0000_0001);
    drive(64'h0);
    wr(7'h04, 32'hffff_ffff);
    check_all("R10 setup");
    @(negedge clk); irq_in[0] = 1'b1;
    @(negedge clk);
    @(negedge clk); reg_addr = 7'h04; reg_wdata = 32'h1; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    m_in[0] = 1'b1; m_lat[0] = 1'b1;
    repeat (2) @(negedge clk);
    check_all("R10 set wins");

    rd(7'h40, d); chk("R2 unmapped group", 64'(d), 64'h0);
    rd(7'h30, d); chk("R2 write-only reads zero", 64'(d), 64'h0);
    wr(7'h50, 32'hffff_ffff);
    check_all("R2 unmapped write ignored");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule